// File: doc/BRIEF.md
# Four-Way Cache Tag Lookup with Recency Ranking

This block holds the tag and replacement state of a four-way set-associative cache with 128 sets. Each way holds four words. For every way of every set it keeps an 11-bit frame tag, four per-word dirty flags, four per-word invalid flags, a whole-entry invalid flag and a 2-bit recency rank. A request names a set, a word offset within the set's four words, a cycle kind and a translated 11-bit frame number. In the same cycle, the block answers with hit or miss, a one-hot way and the write-back needs of the victim. On the next clock edge it updates the stored state.

The rule for a hit depends on the cycle kind. An instruction fetch needs both words of the addressed pair to be valid. A data fetch needs only the addressed word to be valid. A store check or an I/O probe needs only a matching tag. On a miss, the victim is the way ranked least recently used. The block flags when that victim holds dirty words, and flags separately when some of those dirty words lie in the pair that the current cycle does not read, so that an extra dump cycle must follow. Memory-store and processor-store cycles write tags and flags into ways chosen by the requester. An I/O probe can kill a matching entry.

Top module: `cache_tag_lookup`

## Requirements
- R1: Synchronous active-low reset. It marks every entry and every word invalid, clears all dirty flags and sets the rank of way w to w. The first lookup after reset therefore misses with way_oh = 4'b1000.
- R2: A way matches only if its whole-entry invalid flag is clear and its stored tag equals req_frame. An I/O probe (kind 3) with req_kill high that hits sets the entry-invalid flag of the way it reports.
- R3: Instruction fetch (kind 0) hits on a matching way only if both words of the addressed pair are valid. req_word[1] selects the pair (words 0,1 or words 2,3) and req_word[0] selects the word within the pair.
- R4: Data fetch (kind 1) hits on a matching way when the addressed word is valid, whatever the state of its pair partner.
- R5: Store check (kind 2) and I/O probe (kind 3) hit on a tag match alone, ignoring the per-word invalid flags.
- R6: On a hit, way_oh is the lowest-numbered qualifying way. On a fetch or store-check miss, way_oh is the way whose rank is 3.
- R7: A rank update sets the used way to 0 and adds one to each way ranked below the used way's old rank. Updates happen on kinds 0, 1 and 2, and on a dump cycle (kind 7) with the victim as the used way.
- R8: Ranks do not change on kinds 3, 4 (memory store), 5 (processor store) or 6 (read-around). They also do not change on a kind 0, 1 or 2 miss that raises dump2_needed.
- R9: On a kind 0, 1 or 2 miss, wb_needed is high when the victim is valid and holds any dirty word. dump2_needed is high when the victim is valid and has a dirty word in the pair not addressed. An I/O probe never raises either flag, and on a miss it reports way_oh = 0.
- R10: A dump cycle (kind 7) never hits. It reports the rank-3 way, and raises wb_needed when that way is valid and dirty in the addressed pair.
- R11: Memory store (kind 4) writes req_frame into each way set in req_way and clears its entry-invalid flag. It makes the addressed pair valid and clean. With req_first high, it also makes the other pair invalid and clean.
- R12: Processor store (kind 5) makes the addressed word valid and dirty in each way set in req_way. With req_new high, it first rewrites the tag and entry-valid state and marks the other three words invalid and clean.
- R13: multi_hit is high on kinds 0 to 3 when more than one valid way matches the tag.
- R14: With req_valid low, all outputs are 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Cycle kind: 0 instruction fetch, 1 data fetch, 2 store check, 3 I/O probe, 4 memory store, 5 processor store, 6 read-around, 7 dump |
| req_set | input | 7 | Set index |
| req_word | input | 2 | Word within the set; bit 1 selects the pair |
| req_frame | input | 11 | Translated frame number |
| req_way | input | 4 | One-hot target way for store kinds |
| req_first | input | 1 | Memory store is the first of its two cycles |
| req_new | input | 1 | Processor store goes to a newly allocated entry |
| req_kill | input | 1 | I/O probe invalidates the entry it hits |
| hit | output | 1 | Lookup hit |
| way_oh | output | 4 | Hit way or victim way, one-hot |
| wb_needed | output | 1 | Victim holds dirty words to write back |
| dump2_needed | output | 1 | A dump cycle must follow for the other pair |
| multi_hit | output | 1 | More than one valid way matched |

## Verification
Victim write-back detection and rank aging fall in the same cycle. When a fetch misses on a dirty victim, the block must raise dump2_needed and also hold back the rank update, while the following dump cycle must apply it. The bench sets this up by making the current rank-3 way dirty in the pair opposite the one it will fetch, then issuing a missing data fetch and a dump cycle. It judges the result from the flags and from which way later misses choose as victim. Random mixes over four sets and four frames reach the same collision by chance, and each result is compared against a bench model of tags, flags and ranks.

// File: rtl/cache_tag_pkg.sv
// Shared constants and the cycle-kind encoding for the tag lookup block.
package cache_tag_pkg;
    localparam int NWAYS  = 4;
    localparam int NWORDS = 4;
    localparam int AGE_W  = 2;

    typedef enum logic [2:0] {
        K_IFETCH  = 3'd0,
        K_DFETCH  = 3'd1,
        K_SCHECK  = 3'd2,
        K_IOPROBE = 3'd3,
        K_MSTORE  = 3'd4,
        K_ESTORE  = 3'd5,
        K_RDAROUND = 3'd6,
        K_DUMP2   = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/cache_tag_match.sv
// Per-way tag comparison and kind-dependent hit qualification.
// Assumes word index bit 1 selects the pair and bit 0 the word in it.
// Only lookup kinds (fetches, store check, I/O probe) can qualify.
module cache_tag_match
    import cache_tag_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input  logic [NWAYS-1:0][TAG_W-1:0]  tags,
    input  logic [NWAYS-1:0]             einv,
    input  logic [NWAYS-1:0][NWORDS-1:0] winv,
    input  cyc_kind_e                    kind,
    input  logic [1:0]                   word,
    input  logic [TAG_W-1:0]             frame,
    output logic [NWAYS-1:0]             match,
    output logic [NWAYS-1:0]             qhit
);
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic pair_ok;
        logic word_ok;
        // Raw tag match, suppressed for a wholly invalid entry.
        assign match[w] = !einv[w] && (tags[w] == frame);
        assign pair_ok  = !winv[w][{word[1], 1'b0}] && !winv[w][{word[1], 1'b1}];
        assign word_ok  = !winv[w][word];
        // Apply the hit rule of the current cycle kind.
        always_comb begin
            case (kind)
                K_IFETCH:            qhit[w] = match[w] && pair_ok;
                K_DFETCH:            qhit[w] = match[w] && word_ok;
                K_SCHECK, K_IOPROBE: qhit[w] = match[w];
                default:             qhit[w] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cache_age_rank.sv
// Recency ranks: picks the rank-3 victim and computes the ranks after
// using a way. Assumes the ranks form a permutation of 0..NWAYS-1.
module cache_age_rank
    import cache_tag_pkg::*;
(
    input  logic [NWAYS-1:0][AGE_W-1:0] ages,
    input  logic [NWAYS-1:0]            used_oh,
    output logic [NWAYS-1:0]            victim_oh,
    output logic [NWAYS-1:0][AGE_W-1:0] new_ages
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NWAYS - 1);

    logic [NWAYS-1:0] cand;
    logic [AGE_W-1:0] used_age;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cand
        assign cand[w] = (ages[w] == OLDEST);
    end
    // Keep only the lowest candidate so the victim is always one-hot.
    assign victim_oh = cand & (~cand + NWAYS'(1));

    // Old rank of the used way.
    always_comb begin
        used_age = '0;
        for (int w = 0; w < NWAYS; w++)
            if (used_oh[w]) used_age = used_age | ages[w];
    end

    for (genvar w = 0; w < NWAYS; w++) begin : g_new
        // Used way becomes newest; younger ways age by one.
        always_comb begin
            if (used_oh[w])                new_ages[w] = '0;
            else if (ages[w] < used_age)   new_ages[w] = ages[w] + AGE_W'(1);
            else                           new_ages[w] = ages[w];
        end
    end
endmodule

// File: rtl/cache_tag_lookup.sv
// Tag, flag and recency storage for a four-way set-associative cache.
// Lookup outputs are combinational from the request and stored state;
// all state changes at the clock edge. Store kinds take their target
// ways from req_way. Synchronous active-low reset.
module cache_tag_lookup
    import cache_tag_pkg::*;
#(
    parameter int SET_W = 7,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [SET_W-1:0] req_set,
    input  logic [1:0]       req_word,
    input  logic [TAG_W-1:0] req_frame,
    input  logic [NWAYS-1:0] req_way,
    input  logic             req_first,
    input  logic             req_new,
    input  logic             req_kill,
    output logic             hit,
    output logic [NWAYS-1:0] way_oh,
    output logic             wb_needed,
    output logic             dump2_needed,
    output logic             multi_hit
);
    localparam int SETS = 1 << SET_W;

    logic [NWAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [NWAYS-1:0][NWORDS-1:0] winv_q  [SETS];
    logic [NWAYS-1:0][NWORDS-1:0] dirty_q [SETS];
    logic [NWAYS-1:0]             einv_q  [SETS];
    logic [NWAYS-1:0][AGE_W-1:0]  age_q   [SETS];

    cyc_kind_e                    kind;
    logic [NWAYS-1:0][AGE_W-1:0]  cur_age;
    logic [NWAYS-1:0][AGE_W-1:0]  nxt_age;
    logic [NWAYS-1:0]             match, qhit, first_q, victim_oh;
    logic [NWORDS-1:0]            own_mask, oth_mask, word_bit;
    logic                         is_lookup, is_alloc, is_dump, fetch_miss;
    logic                         vict_valid, vict_dirty_any, vict_dirty_own, vict_dirty_oth;
    logic                         age_upd;

    assign kind      = cyc_kind_e'(req_kind);
    assign cur_age   = age_q[req_set];
    assign is_lookup = req_valid && (kind inside {K_IFETCH, K_DFETCH, K_SCHECK, K_IOPROBE});
    assign is_alloc  = req_valid && (kind inside {K_IFETCH, K_DFETCH, K_SCHECK});
    assign is_dump   = req_valid && (kind == K_DUMP2);
    assign own_mask  = req_word[1] ? 4'b1100 : 4'b0011;
    assign oth_mask  = ~own_mask;
    assign word_bit  = NWORDS'(1) << req_word;

    cache_tag_match #(.TAG_W(TAG_W)) u_match (
        .tags (tag_q[req_set]),
        .einv (einv_q[req_set]),
        .winv (winv_q[req_set]),
        .kind (kind),
        .word (req_word),
        .frame(req_frame),
        .match(match),
        .qhit (qhit)
    );

    cache_age_rank u_age (
        .ages     (cur_age),
        .used_oh  (way_oh),
        .victim_oh(victim_oh),
        .new_ages (nxt_age)
    );

    // Lowest qualifying way reported on a hit.
    assign first_q = qhit & (~qhit + NWAYS'(1));

    // Victim validity and dirtiness by pair.
    always_comb begin
        vict_valid = 1'b0; vict_dirty_any = 1'b0;
        vict_dirty_own = 1'b0; vict_dirty_oth = 1'b0;
        for (int w = 0; w < NWAYS; w++) begin
            if (victim_oh[w]) begin
                vict_valid     = !einv_q[req_set][w];
                vict_dirty_any = |dirty_q[req_set][w];
                vict_dirty_own = |(dirty_q[req_set][w] & own_mask);
                vict_dirty_oth = |(dirty_q[req_set][w] & oth_mask);
            end
        end
    end

    // Response outputs.
    assign hit          = is_lookup && (|qhit);
    assign fetch_miss   = is_alloc && !(|qhit);
    assign way_oh       = hit ? first_q : ((fetch_miss || is_dump) ? victim_oh : '0);
    assign dump2_needed = fetch_miss && vict_valid && vict_dirty_oth;
    assign wb_needed    = (fetch_miss && vict_valid && vict_dirty_any) ||
                          (is_dump && vict_valid && vict_dirty_own);
    assign multi_hit    = is_lookup && ($countones(match) > 1);
    assign age_upd      = (is_alloc && !dump2_needed) || is_dump;

    // State update: reset, rank aging, store writes and I/O kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                winv_q[s]  <= '1;
                dirty_q[s] <= '0;
                einv_q[s]  <= '1;
                for (int w = 0; w < NWAYS; w++) age_q[s][w] <= AGE_W'(w);
            end
        end else if (req_valid) begin
            if (age_upd) age_q[req_set] <= nxt_age;
            for (int w = 0; w < NWAYS; w++) begin
                if (kind == K_MSTORE && req_way[w]) begin
                    tag_q[req_set][w]  <= req_frame;
                    einv_q[req_set][w] <= 1'b0;
                    winv_q[req_set][w] <= (winv_q[req_set][w] & ~own_mask) |
                                          (req_first ? oth_mask : '0);
                    dirty_q[req_set][w] <= req_first ? '0 : (dirty_q[req_set][w] & oth_mask);
                end
                if (kind == K_ESTORE && req_way[w]) begin
                    if (req_new) begin
                        tag_q[req_set][w]   <= req_frame;
                        einv_q[req_set][w]  <= 1'b0;
                        winv_q[req_set][w]  <= ~word_bit;
                        dirty_q[req_set][w] <= word_bit;
                    end else begin
                        winv_q[req_set][w]  <= winv_q[req_set][w] & ~word_bit;
                        dirty_q[req_set][w] <= dirty_q[req_set][w] | word_bit;
                    end
                end
                if (kind == K_IOPROBE && req_kill && first_q[w])
                    einv_q[req_set][w] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_tag_lookup_chk.sv
// Protocol checks on the lookup block, attached by bind.
module cache_tag_lookup_chk
    import cache_tag_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [2:0]                  req_kind,
    input logic                        hit,
    input logic [NWAYS-1:0]            way_oh,
    input logic                        wb_needed,
    input logic                        dump2_needed,
    input logic                        multi_hit,
    input logic [NWAYS-1:0][AGE_W-1:0] set_ages
);
    AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(way_oh)); // R6
    AST_HIT_HAS_WAY: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (way_oh != '0)); // R6
    AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (((4'b1 << set_ages[0]) | (4'b1 << set_ages[1]) | (4'b1 << set_ages[2]) | (4'b1 << set_ages[3])) == 4'hF)); // R7
    AST_DUMP2_WB: assert property (@(posedge clk) disable iff (!rst_n) dump2_needed |-> (wb_needed && !hit)); // R9
    AST_IO_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3) |-> (!wb_needed && !dump2_needed)); // R9
    AST_DUMP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd7) |-> !hit); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && way_oh == '0 && !wb_needed && !multi_hit)); // R14
endmodule

bind cache_tag_lookup cache_tag_lookup_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .hit(hit), .way_oh(way_oh), .wb_needed(wb_needed), .dump2_needed(dump2_needed),
    .multi_hit(multi_hit), .set_ages(cur_age)
);

// File: tb/cache_tag_lookup_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// each compared against a bench model of tags, flags and ranks.
module cache_tag_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [6:0]  req_set = '0;
    logic [1:0]  req_word = '0;
    logic [10:0] req_frame = '0;
    logic [3:0]  req_way = '0;
    logic        req_first = 1'b0, req_new = 1'b0, req_kill = 1'b0;
    logic        hit, wb_needed, dump2_needed, multi_hit;
    logic [3:0]  way_oh;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [10:0] m_tag   [128][4];
    logic        m_einv  [128][4];
    logic [3:0]  m_winv  [128][4];
    logic [3:0]  m_dirty [128][4];
    int          m_age   [128][4];

    always #4 clk = ~clk;

    cache_tag_lookup dut_i (.*);

    function automatic int m_vict(int s);
        for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) return w;
        return 0;
    endfunction

    function automatic string kind_tag(logic [2:0] k);
        case (k)
            3'd0: return "R3";  3'd1: return "R4";  3'd2: return "R5";  3'd3: return "R5";
            3'd4: return "R11"; 3'd5: return "R12"; 3'd6: return "R8";  default: return "R10";
        endcase
    endfunction

    task automatic op(input logic v, input logic [2:0] k, input int s, input logic [1:0] wd,
                      input logic [10:0] fr, input logic [3:0] wy, input logic fi, input logic nw,
                      input logic kl, input string tag);
        logic [3:0] q, mt, own, oth, wbit;
        logic look, alloc, dmp, e_hit, e_wb, e_d2, e_multi, upd, vv;
        logic [3:0] e_way;
        int vic, used, nm, ua;
        @(negedge clk);
        req_valid = v; req_kind = k; req_set = 7'(s); req_word = wd; req_frame = fr;
        req_way = wy; req_first = fi; req_new = nw; req_kill = kl;
        #2;
        look  = v && k <= 3'd3;
        alloc = v && k <= 3'd2;
        dmp   = v && k == 3'd7;
        own   = wd[1] ? 4'b1100 : 4'b0011;
        oth   = ~own;
        wbit  = 4'b1 << wd;
        q = '0; mt = '0; nm = 0;
        for (int w = 0; w < 4; w++) begin
            mt[w] = !m_einv[s][w] && m_tag[s][w] == fr;
            if (mt[w]) nm++;
            case (k)
                3'd0: q[w] = mt[w] && !m_winv[s][w][{wd[1],1'b0}] && !m_winv[s][w][{wd[1],1'b1}];
                3'd1: q[w] = mt[w] && !m_winv[s][w][wd];
                3'd2, 3'd3: q[w] = mt[w];
                default: q[w] = 1'b0;
            endcase
        end
        used = 0;
        for (int w = 3; w >= 0; w--) if (q[w]) used = w;
        vic   = m_vict(s);
        vv    = !m_einv[s][vic];
        e_hit = look && q != 0;
        e_way = e_hit ? 4'(1 << used) : ((alloc || dmp) ? 4'(1 << vic) : 4'b0);
        e_d2  = alloc && !e_hit && vv && (m_dirty[s][vic] & oth) != 0;
        e_wb  = (alloc && !e_hit && vv && m_dirty[s][vic] != 0) ||
                (dmp && vv && (m_dirty[s][vic] & own) != 0);
        e_multi = look && nm > 1;
        upd   = (alloc && !e_d2) || dmp;
        checks++;
        if ({hit, way_oh, wb_needed, dump2_needed, multi_hit} !== {e_hit, e_way, e_wb, e_d2, e_multi}) begin
            fails++;
            $display("FAIL %s kind=%0d set=%0d got hit/way/wb/d2/multi=%b exp=%b", tag, k, s,
                     {hit, way_oh, wb_needed, dump2_needed, multi_hit}, {e_hit, e_way, e_wb, e_d2, e_multi});
        end
        @(posedge clk); #1;
        if (!v) return;
        if (upd) begin
            int uw;
            uw = e_hit ? used : vic;
            ua = m_age[s][uw];
            for (int w = 0; w < 4; w++)
                if (w == uw) m_age[s][w] = 0;
                else if (m_age[s][w] < ua) m_age[s][w]++;
        end
        for (int w = 0; w < 4; w++) begin
            if (k == 3'd4 && wy[w]) begin
                m_tag[s][w] = fr; m_einv[s][w] = 1'b0;
                m_winv[s][w] = (m_winv[s][w] & ~own) | (fi ? oth : 4'b0);
                m_dirty[s][w] = fi ? 4'b0 : (m_dirty[s][w] & oth);
            end
            if (k == 3'd5 && wy[w]) begin
                if (nw) begin
                    m_tag[s][w] = fr; m_einv[s][w] = 1'b0;
                    m_winv[s][w] = ~wbit; m_dirty[s][w] = wbit;
                end else begin
                    m_winv[s][w] &= ~wbit; m_dirty[s][w] |= wbit;
                end
            end
        end
        if (k == 3'd3 && kl && e_hit) m_einv[s][used] = 1'b1;
    endtask

    initial begin
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 4; w++) begin
                m_tag[s][w] = '0; m_einv[s][w] = 1'b1; m_winv[s][w] = 4'hF;
                m_dirty[s][w] = '0; m_age[s][w] = w;
            end
        void'($urandom(32'd20240613));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, first lookup misses on way 3
        op(1, 3'd1, 5, 2'd0, 11'd7, 4'b0, 0, 0, 0, "R1");
        // R14: idle request, no effect
        op(0, 3'd4, 5, 2'd0, 11'd7, 4'b0001, 1, 0, 0, "R14");
        // R11: fill pair 0 of way 0
        op(1, 3'd4, 5, 2'd0, 11'd7, 4'b0001, 1, 0, 0, "R11");
        op(1, 3'd1, 5, 2'd1, 11'd7, 4'b0, 0, 0, 0, "R4");
        op(1, 3'd0, 5, 2'd1, 11'd7, 4'b0, 0, 0, 0, "R3");
        op(1, 3'd0, 5, 2'd2, 11'd7, 4'b0, 0, 0, 0, "R3");
        op(1, 3'd2, 5, 2'd2, 11'd7, 4'b0, 0, 0, 0, "R5");
        op(1, 3'd4, 5, 2'd2, 11'd7, 4'b0001, 0, 0, 0, "R11");
        op(1, 3'd0, 5, 2'd3, 11'd7, 4'b0, 0, 0, 0, "R3");
        op(1, 3'd5, 5, 2'd3, 11'd7, 4'b0001, 0, 0, 0, "R12");
        op(1, 3'd6, 5, 2'd0, 11'd7, 4'b0, 0, 0, 0, "R8");
        op(1, 3'd1, 5, 2'd0, 11'd50, 4'b0, 0, 0, 0, "R6");
        // R2: I/O kill then the entry no longer matches
        op(1, 3'd3, 5, 2'd0, 11'd7, 4'b0, 0, 0, 1, "R2");
        op(1, 3'd2, 5, 2'd0, 11'd7, 4'b0, 0, 0, 0, "R2");
        op(1, 3'd3, 5, 2'd0, 11'd99, 4'b0, 0, 0, 0, "R9");
        // R13: same tag placed in two ways
        op(1, 3'd4, 9, 2'd0, 11'd9, 4'b0010, 1, 0, 0, "R11");
        op(1, 3'd4, 9, 2'd0, 11'd9, 4'b0100, 1, 0, 0, "R11");
        op(1, 3'd2, 9, 2'd0, 11'd9, 4'b0, 0, 0, 0, "R13");
        // R8/R9/R10: dirty victim in other pair forces a dump cycle
        op(1, 3'd5, 9, 2'd2, 11'd20, 4'(1 << m_vict(9)), 0, 1, 0, "R12");
        op(1, 3'd1, 9, 2'd0, 11'd30, 4'b0, 0, 0, 0, "R9");
        op(1, 3'd1, 9, 2'd0, 11'd31, 4'b0, 0, 0, 0, "R8");
        op(1, 3'd7, 9, 2'd2, 11'd30, 4'b0, 0, 0, 0, "R10");
        op(1, 3'd1, 9, 2'd0, 11'd32, 4'b0, 0, 0, 0, "R7");
        // Random mix over a small set and frame space
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 7));
            op($urandom_range(0, 9) != 0, k, $urandom_range(0, 3), 2'($urandom_range(0, 3)),
               11'($urandom_range(0, 3)), 4'(1 << $urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               kind_tag(k));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule